// File: doc/BRIEF.md
# Elapsed-Time and Interval Counter

This block keeps elapsed wall-clock time in four cascaded byte registers (fractional 1/128 s, seconds, minutes and hours). They advance on an externally supplied 128 Hz tick pulse. Next to this clock sits an interval timer. An 8-bit counter steps once per unit of a selectable timebase and is compared against a programmed interval length. When the two agree, a sticky interrupt flag is raised, and the counter either reloads from zero or halts until software re-arms it.

Software reaches every register over a plain single-cycle register bus. A write lands on the clock edge with `bus_we` high. A read is combinational from `bus_addr`. The interrupt flag is driven straight out on `irq_o` for an external interrupt controller.

Top module: `time_interval_counter`

## Requirements
- R1: After reset all count registers read 0, the control register (address 0) reads 0x40, and `irq_o` is 0. Control bits: [0] clock run, [1] interval run, [2] interrupt flag, [3] one-shot, [5:4] timebase, [6] always reads 1, [7] reads 0.
- R2: While the clock run bit is 1, each `tick_i` pulse adds one to the fractional register (address 2).
- R3: The fractional register wraps 127 to 0, seconds (address 3) and minutes (address 4) wrap 59 to 0, and hours (address 5) wraps 255 to 0. Each wrap adds one to the next register in the same cycle.
- R4: While the clock run bit is 0, ticks leave all four elapsed-time registers unchanged.
- R5: Timebase code 0 steps the interval counter (address 6, read-only) on every counted tick. When a step would make it equal to the interval register (address 1), the flag is set, and in reload mode (one-shot = 0) the counter returns to 0 and counting continues.
- R6: In one-shot mode the counter holds the matched value after the match and ignores further steps while the interval run bit stays 1.
- R7: Writing the interval run bit as 0 clears the interval counter to 0 and re-arms a halted one-shot.
- R8: Timebase code 1 steps the interval counter only when the fractional register wraps, that is once per second.
- R9: Timebase code 3 steps the interval counter only when the minutes register wraps, that is once per hour. Code 2 steps it on a seconds wrap.
- R10: A control write loads the flag from bit 2, so writing 0 clears `irq_o`. A match in the same cycle takes priority over the write.
- R11: A bus write to an elapsed-time register loads it in place of counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse at 128 Hz |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_o | output | 1 | Interval interrupt flag |

## Verification
The hardest situations to reach are the slow timebases: an hourly step needs 460,800 ticks if the clock only runs forward. The bench instead preloads the fractional, seconds and minutes registers to their last values over the bus. A single tick then ripples a carry through every stage, which produces a minutes wrap and checks the full cascade in one cycle. The bench also preloads the fractional register just below its wrap, so that one tick shows no step in seconds mode and the next tick does.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int unsigned NSTAGE = 4;
  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_LIMIT = 3'd1,
    A_FRAC  = 3'd2,
    A_SEC   = 3'd3,
    A_MIN   = 3'd4,
    A_HOUR  = 3'd5,
    A_COUNT = 3'd6
  } tic_addr_e;
  typedef enum logic [1:0] {
    TB_TICK = 2'd0,
    TB_SEC  = 2'd1,
    TB_MIN  = 2'd2,
    TB_HOUR = 2'd3
  } tic_base_e;
  localparam int CB_CLK    = 0;
  localparam int CB_IVAL   = 1;
  localparam int CB_FLAG   = 2;
  localparam int CB_SINGLE = 3;
  localparam int CB_SEL_LO = 4;
endpackage

// File: rtl/tic_stage.sv
module tic_stage #(
  parameter int W   = 8,
  parameter int MAX = 59
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q,
  output logic         wrap
);
  localparam logic [W-1:0] LIM = W'(MAX);

  assign wrap = inc && (q >= LIM);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (ld)   q <= ld_val;
    else if (wrap) q <= '0;
    else if (inc)  q <= q + W'(1);
  end
endmodule

// File: rtl/tic_interval.sv
module tic_interval #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         single,
  input  logic         step,
  input  logic [W-1:0] limit,
  input  logic         flag_wr,
  input  logic         flag_wdata,
  output logic [W-1:0] cnt,
  output logic         stopped,
  output logic         flag
);
  logic [W-1:0] nxt;
  logic         hit;

  assign nxt = cnt + W'(1);
  assign hit = en && step && !stopped && (nxt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      stopped <= 1'b0;
    end else if (!en) begin
      cnt     <= '0;
      stopped <= 1'b0;
    end else if (hit) begin
      cnt     <= single ? nxt : '0;
      stopped <= single;
    end else if (step && !stopped) begin
      cnt <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (hit)     flag <= 1'b1;
    else if (flag_wr) flag <= flag_wdata;
  end
endmodule

// File: rtl/time_interval_counter.sv
module time_interval_counter
  import tic_pkg::*;
#(
  parameter int W        = 8,
  parameter int FRAC_MAX = 127,
  parameter int SEC_MAX  = 59,
  parameter int MIN_MAX  = 59,
  parameter int HOUR_MAX = 255
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         bus_we,
  input  logic [2:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         irq_o
);
  localparam int STAGE_MAX [NSTAGE] = '{FRAC_MAX, SEC_MAX, MIN_MAX, HOUR_MAX};

  logic         clk_en, ival_en, ival_single;
  logic [1:0]   tb_sel;
  logic [W-1:0] limit_q;
  logic [W-1:0] stage_q   [NSTAGE];
  logic         stage_inc [NSTAGE];
  logic         stage_wrap[NSTAGE];
  logic         unit_step;
  logic [W-1:0] ival_cnt;
  logic         ival_stopped;
  logic         ctrl_wr;

  assign ctrl_wr = bus_we && (bus_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_en      <= 1'b0;
      ival_en     <= 1'b0;
      ival_single <= 1'b0;
      tb_sel      <= TB_TICK;
      limit_q     <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_CTRL) begin
        clk_en      <= bus_wdata[CB_CLK];
        ival_en     <= bus_wdata[CB_IVAL];
        ival_single <= bus_wdata[CB_SINGLE];
        tb_sel      <= bus_wdata[CB_SEL_LO +: 2];
      end
      if (bus_addr == A_LIMIT) limit_q <= bus_wdata;
    end
  end

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign stage_inc[i] = tick_i && clk_en;
    end else begin : g_next
      assign stage_inc[i] = stage_wrap[i-1];
    end
    tic_stage #(.W(W), .MAX(STAGE_MAX[i])) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (stage_inc[i]),
      .ld    (bus_we && (bus_addr == 3'(int'(A_FRAC) + i))),
      .ld_val(bus_wdata),
      .q     (stage_q[i]),
      .wrap  (stage_wrap[i])
    );
  end

  always_comb begin
    unique case (tb_sel)
      TB_TICK: unit_step = stage_inc[0];
      TB_SEC:  unit_step = stage_wrap[0];
      TB_MIN:  unit_step = stage_wrap[1];
      default: unit_step = stage_wrap[2];
    endcase
  end

  tic_interval #(.W(W)) u_ival (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ival_en),
    .single    (ival_single),
    .step      (unit_step),
    .limit     (limit_q),
    .flag_wr   (ctrl_wr),
    .flag_wdata(bus_wdata[CB_FLAG]),
    .cnt       (ival_cnt),
    .stopped   (ival_stopped),
    .flag      (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL:  bus_rdata = W'({1'b0, 1'b1, tb_sel, ival_single, irq_o, ival_en, clk_en});
      A_LIMIT: bus_rdata = limit_q;
      A_FRAC:  bus_rdata = stage_q[0];
      A_SEC:   bus_rdata = stage_q[1];
      A_MIN:   bus_rdata = stage_q[2];
      A_HOUR:  bus_rdata = stage_q[3];
      A_COUNT: bus_rdata = ival_cnt;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tic_checker.sv
module tic_checker #(
  parameter int W        = 8,
  parameter int FRAC_MAX = 127
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_i,
  input logic         bus_we,
  input logic [2:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic         irq_o,
  input logic         clk_en,
  input logic         ival_en,
  input logic         ival_stopped,
  input logic         unit_step,
  input logic [W-1:0] ival_cnt,
  input logic [W-1:0] frac_q,
  input logic [W-1:0] sec_q,
  input logic [W-1:0] min_q,
  input logic [W-1:0] hour_q
);
  // R2
  frac_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && tick_i && !bus_we && frac_q < W'(FRAC_MAX)) |=> frac_q == $past(frac_q) + W'(1));

  // R4
  clock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !bus_we) |=> $stable({frac_q, sec_q, min_q, hour_q}));

  // R7
  ival_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ival_en |=> ival_cnt == '0);

  // R6
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ival_en && ival_stopped) |=> (!ival_en || $stable(ival_cnt)));

  // R10
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(unit_step) || $past(bus_we && bus_addr == 3'd0 && bus_wdata[2])));
endmodule

bind time_interval_counter tic_checker #(.W(W), .FRAC_MAX(FRAC_MAX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .irq_o       (irq_o),
  .clk_en      (clk_en),
  .ival_en     (ival_en),
  .ival_stopped(ival_stopped),
  .unit_step   (unit_step),
  .ival_cnt    (ival_cnt),
  .frac_q      (stage_q[0]),
  .sec_q       (stage_q[1]),
  .min_q       (stage_q[2]),
  .hour_q      (stage_q[3])
);

// File: tb/time_interval_counter_test.sv
module time_interval_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  time_interval_counter uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  // ctrl: [0] clk run [1] ival run [2] flag [3] one-shot [5:4] base
  function automatic logic [7:0] cfg(input bit c, input bit iv, input bit sh, input logic [1:0] b);
    return {2'b00, b, sh, 1'b0, iv, c};
  endfunction

  task automatic clear_all();
    wr(3'd0, 8'h00);
    for (int a = 1; a < 6; a++) wr(3'(a), 8'h00);
  endtask

  task automatic t_reset();
    int v;
    for (int a = 1; a < 7; a++) begin rd(3'(a), v); check("R1 count reset", v, 0); end
    rd(3'd0, v); check("R1 ctrl reset", v, 8'h40);
    check("R1 irq reset", int'(irq_o), 0);
  endtask

  task automatic t_count();
    int v;
    clear_all();
    wr(3'd0, cfg(1, 0, 0, 2'd0));
    tick(5);
    rd(3'd2, v); check("R2 frac after 5 ticks", v, 5);
    wr(3'd0, cfg(0, 0, 0, 2'd0));
    tick(3);
    rd(3'd2, v); check("R4 frac frozen", v, 5);
  endtask

  task automatic t_cascade();
    int v;
    clear_all();
    wr(3'd2, 8'd127); wr(3'd3, 8'd10);
    wr(3'd0, cfg(1, 0, 0, 2'd0));
    tick(1);
    rd(3'd2, v); check("R3 frac wrap", v, 0);
    rd(3'd3, v); check("R3 sec carry", v, 11);
    wr(3'd2, 8'd127); wr(3'd3, 8'd59); wr(3'd4, 8'd59); wr(3'd5, 8'd255);
    tick(1);
    rd(3'd3, v); check("R3 sec wrap", v, 0);
    rd(3'd4, v); check("R3 min wrap", v, 0);
    rd(3'd5, v); check("R3 hour wrap", v, 0);
    wr(3'd0, cfg(0, 0, 0, 2'd0));
    wr(3'd3, 8'd33);
    rd(3'd3, v); check("R11 sec load", v, 33);
  endtask

  task automatic t_reload();
    int v;
    clear_all();
    wr(3'd1, 8'd3);
    wr(3'd0, cfg(1, 1, 0, 2'd0));
    tick(2);
    check("R5 no irq before match", int'(irq_o), 0);
    rd(3'd6, v); check("R5 count 2", v, 2);
    tick(1);
    check("R5 irq on match", int'(irq_o), 1);
    rd(3'd6, v); check("R5 reload to 0", v, 0);
    wr(3'd0, cfg(1, 1, 0, 2'd0));
    check("R10 flag cleared by write", int'(irq_o), 0);
    tick(3);
    check("R5 second interval irq", int'(irq_o), 1);
  endtask

  task automatic t_oneshot();
    int v;
    clear_all();
    wr(3'd1, 8'd2);
    wr(3'd0, cfg(1, 1, 1, 2'd0));
    tick(2);
    check("R6 irq on match", int'(irq_o), 1);
    tick(4);
    rd(3'd6, v); check("R6 count held", v, 2);
    wr(3'd0, cfg(1, 0, 1, 2'd0));
    rd(3'd6, v); check("R7 disable clears count", v, 0);
    wr(3'd0, cfg(1, 1, 1, 2'd0));
    tick(1);
    rd(3'd6, v); check("R7 rearmed counts", v, 1);
  endtask

  task automatic t_seconds();
    clear_all();
    wr(3'd2, 8'd126);
    wr(3'd1, 8'd1);
    wr(3'd0, cfg(1, 1, 0, 2'd1));
    tick(1);
    check("R8 no step before wrap", int'(irq_o), 0);
    tick(1);
    check("R8 step on frac wrap", int'(irq_o), 1);
  endtask

  task automatic t_hours();
    clear_all();
    wr(3'd2, 8'd127); wr(3'd3, 8'd59); wr(3'd4, 8'd58);
    wr(3'd1, 8'd1);
    wr(3'd0, cfg(1, 1, 0, 2'd3));
    tick(1);
    check("R9 no step on sec wrap", int'(irq_o), 0);
    wr(3'd2, 8'd127); wr(3'd3, 8'd59);
    tick(1);
    check("R9 step on min wrap", int'(irq_o), 1);
    clear_all();
    wr(3'd2, 8'd127); wr(3'd3, 8'd59);
    wr(3'd1, 8'd1);
    wr(3'd0, cfg(1, 1, 0, 2'd2));
    tick(1);
    check("R9 minutes base steps on sec wrap", int'(irq_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_cascade();
    t_reload();
    t_oneshot();
    t_seconds();
    t_hours();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule